// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block drives the chip-wide active-low reset from two sources. The first is a digital supply-low flag, which comes from an analog comparator outside the block. The second is a software watchdog: a kick line that firmware toggles from time to time. While the supply flag is high, reset is held asserted. If the kick line shows no transition for a programmed number of reference-clock cycles, the block issues a reset pulse. Both sources pass through one pulse stretcher, so every reset lasts a guaranteed minimum time after its cause has gone away.

Both inputs are asynchronous to the reference clock, so each passes through a two-flop synchronizer. Firmware may kick on a rising or a falling transition of the kick line. The watchdog counter is cleared and frozen for as long as reset is asserted, and it begins counting only when reset is released.

There is no reset input. The block leaves its power-on register values as a reset that is already stretching, so a full-length power-up reset appears on the output. All delays are parameters in clock cycles. The default values give 1.6 s and 200 ms at 50 MHz.

Top module: `reset_supervisor`

## Requirements
- R1: From time zero, `rst_n_o` is low. It goes high at the PULSE_CYC-th rising clock edge, provided no trigger occurs in that time.
- R2: When `supply_low_i` goes high before clock edge 1, `rst_n_o` goes low at edge 3 (two synchronizer stages plus one output register). It stays high before that edge.
- R3: `rst_n_o` stays low at every edge for as long as `supply_low_i` is held high.
- R4: When `supply_low_i` falls before edge 1, `rst_n_o` goes high at edge PULSE_CYC+2. A supply-low pulse of a single cycle therefore yields exactly PULSE_CYC cycles of low reset.
- R5: With no kick transition, `rst_n_o` goes low TIMEOUT_CYC+1 edges after it went high.
- R6: A reset caused by the watchdog lasts exactly PULSE_CYC cycles.
- R7: A rising or a falling transition of `kick_i` before edge 1 restarts the timeout. Without further kicks, `rst_n_o` then goes low at edge TIMEOUT_CYC+4.
- R8: Kick transitions spaced TIMEOUT_CYC cycles apart or closer never cause a reset. A spacing of TIMEOUT_CYC+1 cycles does cause one.
- R9: Kick transitions while reset is low have no effect. The next timeout is still measured from the release, as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| supply_low_i | input | 1 | Digitized undervoltage flag, asynchronous, high when the supply is low |
| kick_i | input | 1 | Watchdog kick line, asynchronous; any transition counts as a kick |
| rst_n_o | output | 1 | Registered system reset, active low |

## Verification
A watchdog count that is off by one moves the falling edge of `rst_n_o` by one cycle, measured from release or from the last kick. Kicks are swept at every spacing up to and just past the limit, so any skew in when the count clears shows up within one timeout period. A stretcher count, or a synchronizer depth, that is off by one shifts the fall or the rise of reset by a cycle relative to the supply flag. Every supply-pulse length is compared cycle by cycle, so the error appears within PULSE_CYC+2 cycles. A counter that is not frozen during reset shows up as a timeout that ends early after release.

// File: rtl/rsup_pkg.sv
// Shared definitions for the reset supervisor.
// Assumes: nothing beyond standard SystemVerilog.
package rsup_pkg;

    // Stretcher state: reset driven or released
    typedef enum logic {
        RST_RELEASED = 1'b0,
        RST_HELD     = 1'b1
    } rst_state_e;

    // Counter width able to hold values 0 .. limit-1 (minimum 1 bit)
    function automatic int cnt_width(input int limit);
        return (limit > 2) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/rsup_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 1; all flops power up low.
module rsup_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic d_i,
    output logic q_o
);

    generate
        if (STAGES == 1) begin : g_single
            logic s_q = 1'b0;
            // Single stage: sample the input
            always_ff @(posedge clk_i) s_q <= d_i;
            assign q_o = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q = '0;
            // Shift the input through the chain
            always_ff @(posedge clk_i) chain_q <= {chain_q[STAGES-2:0], d_i};
            assign q_o = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rsup_wdog.sv
// Watchdog timer. It counts cycles since the last kick and raises a
// one-cycle fire pulse after TIMEOUT_CYC quiet cycles.
// Assumes: kick_i is a synchronous one-cycle edge strobe; hold_i is high
// while system reset is asserted and keeps the count cleared.
module rsup_wdog
    import rsup_pkg::*;
#(
    parameter int TIMEOUT_CYC = 80_000_000
) (
    input  logic clk_i,
    input  logic hold_i,
    input  logic kick_i,
    output logic fire_o
);

    localparam int             WW   = cnt_width(TIMEOUT_CYC);
    localparam logic [WW-1:0]  LAST = WW'(TIMEOUT_CYC - 1);

    logic [WW-1:0] cnt_q  = '0;
    logic          fire_q = 1'b0;

    // Count quiet cycles; clear on a kick or while held; fire at the limit
    always_ff @(posedge clk_i) begin
        if (hold_i || kick_i) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            fire_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            fire_q <= 1'b0;
        end
    end

    assign fire_o = fire_q;

endmodule

// File: rtl/rsup_stretch.sv
// Reset stretcher. Reset is held while the trigger is high and for
// PULSE_CYC cycles after the trigger was last seen high.
// Assumes: PULSE_CYC >= 2. The power-on state is "held", with the count
// at zero, so a full pulse also follows power-up.
module rsup_stretch
    import rsup_pkg::*;
#(
    parameter int PULSE_CYC = 10_000_000
) (
    input  logic clk_i,
    input  logic trig_i,
    output logic active_o
);

    localparam int            CW   = cnt_width(PULSE_CYC);
    localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

    rst_state_e    state_q = RST_HELD;
    logic [CW-1:0] cnt_q   = '0;

    // Restart on a trigger, otherwise count down the remaining hold time
    always_ff @(posedge clk_i) begin
        if (trig_i) begin
            state_q <= RST_HELD;
            cnt_q   <= '0;
        end else if (state_q == RST_HELD) begin
            if (cnt_q == LAST) begin
                state_q <= RST_RELEASED;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active_o = (state_q == RST_HELD);

endmodule

// File: rtl/reset_supervisor.sv
// Top level of the reset supervisor. It synchronizes the supply-low flag and
// the kick line, detects kick transitions, times out the watchdog and
// stretches every reset cause into a reset of at least minimum length.
// Assumes: both inputs are asynchronous; the output is registered.
module reset_supervisor #(
    parameter int TIMEOUT_CYC = 80_000_000,
    parameter int PULSE_CYC   = 10_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic supply_low_i,
    input  logic kick_i,
    output logic rst_n_o
);

    logic supply_low_s;
    logic kick_s;
    logic kick_prev_q = 1'b0;
    logic kick_edge;
    logic wd_fire;
    logic rst_active;

    rsup_sync #(.STAGES(SYNC_STAGES)) u_sync_supply (
        .clk_i (clk_i),
        .d_i   (supply_low_i),
        .q_o   (supply_low_s)
    );

    rsup_sync #(.STAGES(SYNC_STAGES)) u_sync_kick (
        .clk_i (clk_i),
        .d_i   (kick_i),
        .q_o   (kick_s)
    );

    // Remember the previous synchronized kick level for edge detection
    always_ff @(posedge clk_i) kick_prev_q <= kick_s;

    assign kick_edge = kick_s ^ kick_prev_q;

    rsup_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
        .clk_i  (clk_i),
        .hold_i (rst_active),
        .kick_i (kick_edge),
        .fire_o (wd_fire)
    );

    rsup_stretch #(.PULSE_CYC(PULSE_CYC)) u_stretch (
        .clk_i    (clk_i),
        .trig_i   (supply_low_s | wd_fire),
        .active_o (rst_active)
    );

    assign rst_n_o = ~rst_active;

endmodule

// File: rtl/rsup_checker.sv
// Assertion checker for reset_supervisor, attached with bind.
// Assumes: it is enabled from the second clock edge onward.
module rsup_checker #(
    parameter int PULSE_CYC = 10_000_000
) (
    input logic clk_i,
    input logic rst_n_o,
    input logic supply_low_s,
    input logic wd_fire,
    input logic kick_edge
);

    localparam int             RW  = $clog2(PULSE_CYC + 2) + 1;
    localparam logic [RW-1:0]  MAX = '1;

    logic          armed_q   = 1'b0;
    logic [RW-1:0] low_run_q = '0;

    // Enable the properties after the first edge
    always_ff @(posedge clk_i) armed_q <= 1'b1;

    // Length of the current low run of the reset output, saturating
    always_ff @(posedge clk_i) begin
        if (rst_n_o)                low_run_q <= '0;
        else if (low_run_q != MAX)  low_run_q <= low_run_q + 1'b1;
    end

    // R2
    supply_forces_rst_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
        supply_low_s |=> !rst_n_o);

    // R5
    fire_forces_rst_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
        wd_fire |=> !rst_n_o);

    // R4 R6
    min_pulse_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
        $rose(rst_n_o) |-> (low_run_q >= RW'(PULSE_CYC)));

    // R9
    no_fire_in_rst_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
        !rst_n_o |=> !wd_fire);

    // R7
    kick_clears_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
        (kick_edge && rst_n_o) |=> !wd_fire);

endmodule

bind reset_supervisor rsup_checker #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk_i        (clk_i),
    .rst_n_o      (rst_n_o),
    .supply_low_s (supply_low_s),
    .wd_fire      (wd_fire),
    .kick_edge    (kick_edge)
);

// File: tb/tb_reset_supervisor.sv
module tb_reset_supervisor;

    localparam int T = 40;
    localparam int P = 12;

    logic clk = 1'b0;
    logic supply_low = 1'b0;
    logic kick = 1'b0;
    logic rst_n;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    reset_supervisor #(.TIMEOUT_CYC(T), .PULSE_CYC(P), .SYNC_STAGES(2)) dut (
        .clk_i        (clk),
        .supply_low_i (supply_low),
        .kick_i       (kick),
        .rst_n_o      (rst_n)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count edges until rst_n reaches a level, capped at a limit
    task automatic edges_until(input logic lvl, output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (rst_n !== lvl && n < 4 * (T + P));
    endtask

    initial begin
        int n;
        int m;
        int lens [7] = '{1, 2, 3, 5, 8, 20, 30};
        #1;
        // R1: low at time zero, released after P edges
        chk(rst_n === 1'b0, "R1", int'(rst_n), 0);
        edges_until(1'b1, n);
        chk(n == P, "R1", n, P);

        // R5: no kicks, timeout counted from release
        edges_until(1'b0, n);
        chk(n == T + 1, "R5", n, T + 1);

        // R9: kicks during reset do nothing; R6 pulse length
        for (int i = 0; i < 3; i++) begin
            tick();
            kick = ~kick;
        end
        edges_until(1'b1, m);
        chk(m + 3 == P, "R6", m + 3, P);
        edges_until(1'b0, n);
        chk(n == T + 1, "R9", n, T + 1);
        edges_until(1'b1, n);
        chk(n == P, "R6", n, P);

        // R2 R3 R4: supply-low pulses of several lengths, cycle by cycle
        foreach (lens[j]) begin
            int len = lens[j];
            supply_low = 1'b1;
            for (int t = 1; t <= len + P + 2; t++) begin
                logic expv;
                string req;
                tick();
                expv = (t >= 3 && t < len + P + 2) ? 1'b0 : 1'b1;
                req  = (t < 3) ? "R2" : ((t <= len) ? "R3" : "R4");
                chk(rst_n === expv, req, int'(rst_n), int'(expv));
                if (t == len) supply_low = 1'b0;
            end
        end

        // R7 R8: kick spacing sweep over every spacing up to T
        for (int sp = 1; sp <= T; sp++) begin
            int lowcnt = 0;
            for (int k = 0; k < 3; k++) begin
                kick = ~kick;
                if (k < 2) begin
                    for (int c = 0; c < sp; c++) begin
                        tick();
                        if (rst_n !== 1'b1) lowcnt++;
                    end
                end
            end
            chk(lowcnt == 0, "R8", lowcnt, 0);
            edges_until(1'b0, n);
            chk(n == T + 4, "R7", n, T + 4);
            edges_until(1'b1, n);
            chk(n == P, "R6", n, P);
        end

        // R8: spacing of T+1 is too late
        kick = ~kick;
        n = 0;
        do begin
            tick();
            n++;
            if (n == T + 1) kick = ~kick;
        end while (rst_n === 1'b1 && n < 4 * T);
        chk(n == T + 4, "R8", n, T + 4);
        edges_until(1'b1, n);
        chk(n == P, "R6", n, P);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog for a hung run
    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule